// File: doc/BRIEF.md
# Stuff Count Field Decoder

This block decodes the short stuff-count field that a flexible-data-rate CAN frame carries between its payload and its CRC. The frame sequencer feeds it destuffed bits one at a time. Each bit comes with a valid strobe, and the sequencer raises a start marker on the first bit of the field. The block collects four bits, most significant first. The first three are a Gray-coded count and the fourth is a parity bit over them. When the parity bit arrives, the block publishes three results: the count converted to binary, a parity-error flag, and a one-cycle done pulse.

The decoded count is the number of dynamic stuff bits in the frame, modulo 8. The parameter `CHECK_COUNT` enables a cross-check. When it is set, the block keeps its own wrapping count of the dynamic stuff bits reported by the destuffer and flags any difference from the decoded value. Bit sampling, destuffing and CRC work are done by other blocks. Fixed stuff bits never reach this one.

Top module: `sbc_field_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, `sbc_count` is 0 and `sbc_done`, `parity_err` and `count_mismatch` are all low.
- R2: A bit is captured only in a cycle where `bit_vld` is high. `bit_val` is ignored in any other cycle. A strobe with `field_start` high is the first field bit and becomes bit 2 (the MSB) of the Gray code. The next two strobes are bits 1 and 0, and the fourth strobe is the parity bit.
- R3: `sbc_done` is high for exactly one cycle. That cycle is the one right after the clock edge that captures the parity bit.
- R4: With `sbc_done`, `sbc_count` holds the binary value of the Gray code g. Binary bit i is the XOR of g[2] down to g[i].
- R5: With `sbc_done`, `parity_err` is 1 exactly when g[2]^g[1]^g[0] differs from the parity bit. The count is reported either way.
- R6: `sbc_count`, `parity_err` and `count_mismatch` keep their values until the next `sbc_done` pulse.
- R7: A strobe with `field_start` high in the middle of a field abandons the partial field and starts a new one, with that bit as the new MSB.
- R8: Strobes that arrive with no field open (no preceding `field_start`, or after the parity bit) produce no `sbc_done` and leave the outputs unchanged.
- R9: With `CHECK_COUNT`=1, an internal count adds one for each cycle with `dyn_stuff` high and is cleared by `frame_sof`. `frame_sof` wins when both are high in the same cycle. At the parity capture, `count_mismatch` is set when the decoded count differs from the internal count as it stood before that cycle.
- R10: The internal stuff count wraps modulo 8, so ten `dyn_stuff` pulses match a decoded count of 2 (Gray 3'b011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sof | input | 1 | Start of frame; clears the internal stuff count |
| dyn_stuff | input | 1 | One pulse per dynamic stuff bit removed by the destuffer |
| bit_vld | input | 1 | Destuffed bit strobe |
| bit_val | input | 1 | Destuffed bit value |
| field_start | input | 1 | Marks the first bit of the stuff-count field |
| sbc_count | output | 3 | Decoded binary stuff count |
| sbc_done | output | 1 | One-cycle pulse when the field is decoded |
| parity_err | output | 1 | Parity of the Gray bits does not match the parity bit |
| count_mismatch | output | 1 | Decoded count differs from the internal stuff count |

## Verification
Two functions can fall in the same cycle. A `dyn_stuff` pulse can coincide with the capture of the parity bit, and `frame_sof` can coincide with a `dyn_stuff` pulse. The bench drives the stuff pulse on the same falling edge as the fourth field bit. It then judges `count_mismatch` against the count as it stood before that pulse. A follow-up field with no new start of frame confirms that the pulse was still counted. For the second collision, the bench raises `frame_sof` and `dyn_stuff` together and expects a decoded count of 0 to match.

// File: rtl/sbc_field_decoder.sv
module sbc_field_decoder #(
  parameter int GRAY_W      = 3,
  parameter bit CHECK_COUNT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sof,
  input  logic              dyn_stuff,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              field_start,
  output logic [GRAY_W-1:0] sbc_count,
  output logic              sbc_done,
  output logic              parity_err,
  output logic              count_mismatch
);
  localparam int FIELD_W = GRAY_W + 1;
  localparam int IDX_W   = $clog2(FIELD_W);

  logic [GRAY_W-1:0] gray_q;
  logic [GRAY_W-1:0] bin_w;
  logic [GRAY_W-1:0] stuff_cnt;
  logic [IDX_W-1:0]  idx_q;
  logic              active_q;

  for (genvar i = 0; i < GRAY_W; i++) begin : g_g2b
    assign bin_w[i] = ^gray_q[GRAY_W-1:i];
  end

  wire parity_bad = (^gray_q) != bit_val;
  wire last_bit   = bit_vld && active_q && !field_start && (idx_q == IDX_W'(GRAY_W));

  if (CHECK_COUNT) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || frame_sof) stuff_cnt <= '0;
      else if (dyn_stuff)   stuff_cnt <= stuff_cnt + 1'b1;
    end
  end else begin : g_nocnt
    assign stuff_cnt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gray_q         <= '0;
      idx_q          <= '0;
      active_q       <= 1'b0;
      sbc_count      <= '0;
      sbc_done       <= 1'b0;
      parity_err     <= 1'b0;
      count_mismatch <= 1'b0;
    end else begin
      sbc_done <= 1'b0;
      if (bit_vld && field_start) begin
        gray_q   <= {{(GRAY_W-1){1'b0}}, bit_val};
        idx_q    <= IDX_W'(1);
        active_q <= 1'b1;
      end else if (last_bit) begin
        active_q       <= 1'b0;
        sbc_done       <= 1'b1;
        sbc_count      <= bin_w;
        parity_err     <= parity_bad;
        count_mismatch <= CHECK_COUNT && (bin_w != stuff_cnt);
      end else if (bit_vld && active_q) begin
        gray_q <= {gray_q[GRAY_W-2:0], bit_val};
        idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbc_field_decoder_chk.sv
module sbc_field_decoder_chk #(
  parameter int GRAY_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_vld,
  input logic [GRAY_W-1:0] sbc_count,
  input logic              sbc_done,
  input logic              parity_err,
  input logic              count_mismatch
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sbc_count == '0 && !sbc_done && !parity_err && !count_mismatch));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    sbc_done |=> !sbc_done);

  assert_done_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    sbc_done |-> $past(bit_vld));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !sbc_done |-> $stable(sbc_count));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !sbc_done |-> ($stable(parity_err) && $stable(count_mismatch)));
endmodule

bind sbc_field_decoder sbc_field_decoder_chk #(.GRAY_W(GRAY_W)) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .sbc_count(sbc_count),
  .sbc_done(sbc_done), .parity_err(parity_err), .count_mismatch(count_mismatch)
);

// File: tb/sbc_field_decoder_bench.sv
module sbc_field_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, frame_sof, dyn_stuff, bit_vld, bit_val, field_start;
  logic [2:0] sbc_count;
  logic sbc_done, parity_err, count_mismatch;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbc_field_decoder u_sbc_field_decoder (
    .clk(clk), .rst(rst), .frame_sof(frame_sof), .dyn_stuff(dyn_stuff),
    .bit_vld(bit_vld), .bit_val(bit_val), .field_start(field_start),
    .sbc_count(sbc_count), .sbc_done(sbc_done), .parity_err(parity_err),
    .count_mismatch(count_mismatch)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int g2b(input int g);
    int num = g;
    int m = g;
    while (m != 0) begin
      m = m >> 1;
      num = num ^ m;
    end
    return num;
  endfunction

  function automatic logic [2:0] b2g(input int b);
    return 3'(b ^ (b >> 1));
  endfunction

  task automatic put_bit(input logic v, input logic fs, input logic st, input int gaps);
    @(negedge clk);
    bit_vld = 1'b1; bit_val = v; field_start = fs; dyn_stuff = st;
    @(negedge clk);
    bit_vld = 1'b0; field_start = 1'b0; dyn_stuff = 1'b0; bit_val = ~v;
    repeat (gaps) @(negedge clk);
  endtask

  task automatic new_frame(input int pulses);
    @(negedge clk); frame_sof = 1'b1;
    @(negedge clk); frame_sof = 1'b0;
    for (int k = 0; k < pulses; k++) begin
      dyn_stuff = 1'b1; @(negedge clk);
      dyn_stuff = 1'b0; @(negedge clk);
    end
  endtask

  task automatic send_field(input logic [2:0] g, input logic p, input logic st_last, input int gaps);
    put_bit(g[2], 1'b1, 1'b0, gaps);
    put_bit(g[1], 1'b0, 1'b0, gaps);
    put_bit(g[0], 1'b0, 1'b0, gaps);
    check("R3 no early done", sbc_done, 0);
    put_bit(p, 1'b0, st_last, 0);
  endtask

  task automatic t_reset;
    check("R1 count", sbc_count, 0);
    check("R1 done", sbc_done, 0);
    check("R1 perr", parity_err, 0);
    check("R1 mismatch", count_mismatch, 0);
  endtask

  task automatic t_all_codes;
    for (int b = 0; b < 8; b++) begin
      logic [2:0] g = b2g(b);
      new_frame(b);
      send_field(g, ^g, 1'b0, 0);
      check("R3 done", sbc_done, 1);
      check("R4 count", sbc_count, g2b(int'(g)));
      check("R5 good parity", parity_err, 0);
      check("R9 match", count_mismatch, 0);
      @(negedge clk);
      check("R3 one cycle", sbc_done, 0);
      repeat (3) @(negedge clk);
      check("R6 hold", sbc_count, b);
    end
  endtask

  task automatic t_parity_bad;
    new_frame(1);
    send_field(3'b110, 1'b1, 1'b0, 0);
    check("R5 perr", parity_err, 1);
    check("R5 count kept", sbc_count, 4);
    check("R9 mismatch", count_mismatch, 1);
    repeat (2) @(negedge clk);
    check("R6 perr hold", parity_err, 1);
  endtask

  task automatic t_gaps;
    new_frame(6);
    send_field(b2g(6), ^b2g(6), 1'b0, 3);
    check("R2 gapped done", sbc_done, 1);
    check("R2 gapped count", sbc_count, 6);
    check("R2 gapped perr", parity_err, 0);
  endtask

  task automatic t_restart;
    new_frame(3);
    put_bit(1'b1, 1'b1, 1'b0, 0);
    put_bit(1'b1, 1'b0, 1'b0, 0);
    put_bit(1'b0, 1'b1, 1'b0, 0);
    put_bit(1'b1, 1'b0, 1'b0, 0);
    put_bit(1'b0, 1'b0, 1'b0, 0);
    check("R7 no done yet", sbc_done, 0);
    put_bit(1'b1, 1'b0, 1'b0, 0);
    check("R7 done", sbc_done, 1);
    check("R7 count", sbc_count, 3);
    check("R7 perr", parity_err, 0);
  endtask

  task automatic t_orphan;
    for (int k = 0; k < 6; k++) put_bit(k[0], 1'b0, 1'b0, 0);
    check("R8 no done", sbc_done, 0);
    check("R8 count kept", sbc_count, 3);
  endtask

  task automatic t_wrap;
    new_frame(10);
    send_field(3'b011, 1'b0, 1'b0, 0);
    check("R10 count", sbc_count, 2);
    check("R10 wrap match", count_mismatch, 0);
  endtask

  task automatic t_collide;
    new_frame(5);
    send_field(b2g(5), ^b2g(5), 1'b1, 0);
    check("R9 same cycle pulse", count_mismatch, 0);
    send_field(b2g(6), ^b2g(6), 1'b0, 0);
    check("R9 pulse counted", count_mismatch, 0);
    new_frame(2);
    @(negedge clk); frame_sof = 1'b1; dyn_stuff = 1'b1;
    @(negedge clk); frame_sof = 1'b0; dyn_stuff = 1'b0;
    send_field(3'b000, 1'b0, 1'b0, 0);
    check("R9 sof wins", count_mismatch, 0);
  endtask

  initial begin
    rst = 1'b1; frame_sof = 1'b0; dyn_stuff = 1'b0;
    bit_vld = 1'b0; bit_val = 1'b0; field_start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_codes();
    t_parity_bad();
    t_gaps();
    t_restart();
    t_orphan();
    t_wrap();
    t_collide();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule